// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block keeps a host processor in reset while its power is not trustworthy or while its firmware has stopped responding. It drives an active-low, open-drain style reset, modelled as a drive-low enable. Reset is held for a fixed settling period in three cases: after power-good is first seen, after the low-supply comparator flag clears, and after a watchdog timeout. While reset is released, the host must produce falling edges on a pin that it also uses as an SPI chip select. If those edges stop arriving, the block resets the host.

The watchdog interval comes from a two-bit select held in nonvolatile configuration. Three codes pick preset intervals and the fourth code turns the watchdog off. A volatile cause flag tells the host, after it restarts, whether the last reset came from the watchdog or from a low supply. The host clears this flag with a write strobe.

The controller has four states. `ST_HOLD` is the settling period after power-up or after supply recovery. `ST_RUN` has reset released and the watchdog counting. `ST_LOWV` holds reset while the supply is low. `ST_WDOG` is the settling period after a watchdog timeout. The transitions are:
- `ST_HOLD`→`ST_RUN` and `ST_WDOG`→`ST_RUN` when the settle timer completes.
- `ST_RUN`→`ST_WDOG` on watchdog expiry.
- `ST_HOLD`, `ST_RUN` or `ST_WDOG`→`ST_LOWV` when the synchronised low flag is seen.
- `ST_LOWV`→`ST_HOLD` when the synchronised low flag clears.

Top module: `wdsup_top`

## Requirements
- R1: While `pwr_good_i` is low, `rst_drive_o` is 1 and the controller is in `ST_HOLD`. After `pwr_good_i` rises, `rst_drive_o` stays 1 for exactly `SETTLE_CYC` rising clock edges and then falls to 0.
- R2: With reset released and no service edges, `rst_drive_o` returns to 1 exactly N rising edges after release. N is `WD_T0_CYC`, `WD_T1_CYC` or `WD_T2_CYC` for `wd_sel_i` = 0, 1 or 2.
- R3: With `wd_sel_i` = 3, the watchdog never expires and reset stays released.
- R4: A falling edge on `wdi_cs_i` restarts the watchdog count. Holding the pin low, and a rising edge, do not restart it.
- R5: `supply_low_i` passes through a two-stage synchroniser. Reset is asserted on the third rising edge after the flag rises and is held for as long as the flag stays high. After the flag falls, reset is released `SETTLE_CYC + 3` rising edges later.
- R6: A watchdog reset holds `rst_drive_o` at 1 for exactly `SETTLE_CYC` rising edges.
- R7: `cause_wdog_o` is 0 after power-up, is set to 1 on a watchdog timeout, and is set to 0 when a low-supply reset begins.
- R8: A one-cycle pulse on `cause_clr_i` sets `cause_wdog_o` to 0 on the next rising edge.
- R9: The watchdog count is held at zero while reset is asserted. After a watchdog reset ends, the full interval applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Power good, active high; low acts as an asynchronous reset |
| supply_low_i | input | 1 | Digital low-supply comparator flag, asynchronous |
| wdi_cs_i | input | 1 | Watchdog service / SPI chip select; a falling edge services the watchdog |
| wd_sel_i | input | 2 | Interval select from nonvolatile configuration; 3 disables the watchdog |
| cause_clr_i | input | 1 | Host write strobe that clears the cause flag |
| rst_drive_o | output | 1 | Drive-low enable for the open-drain active-low reset |
| cause_wdog_o | output | 1 | 1 if the last reset came from the watchdog, 0 if from low supply |

## Verification
The bench builds the block with `SETTLE_CYC` = 20 and intervals of 30, 50 and 80 cycles instead of hundreds of milliseconds. This makes every select code, every state transition and every exact settle and expiry length reachable within a few thousand cycles. Each interval is measured edge by edge twice, before and after a watchdog reset, which exposes any count that is not cleared. A low-supply episode that lasts longer than any interval shows that reset is held throughout and that the cause flag is overridden.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOWV = 2'd2,
        ST_WDOG = 2'd3
    } sup_state_e;

    localparam logic [1:0] SEL_OFF = 2'd3;

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdsup_settle_timer.sv
module wdsup_settle_timer #(
    parameter int SETTLE_CYC = 20,
    parameter int CNT_W      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == CNT_W'(SETTLE_CYC - 1));

    // R1 / R6: the settle count never passes its terminal value
    assert_settle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CNT_W'(SETTLE_CYC)));
endmodule

// File: rtl/wdsup_wd_timer.sv
module wdsup_wd_timer
    import wdsup_pkg::*;
#(
    parameter int WD_T0_CYC = 30,
    parameter int WD_T1_CYC = 50,
    parameter int WD_T2_CYC = 80,
    parameter int CNT_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       kick_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             active;

    always_comb begin
        unique case (sel_i)
            2'd0:    limit = CNT_W'(WD_T0_CYC);
            2'd1:    limit = CNT_W'(WD_T1_CYC);
            2'd2:    limit = CNT_W'(WD_T2_CYC);
            default: limit = '1;
        endcase
    end

    assign active = run_i && (sel_i != SEL_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || kick_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = active && !kick_i && (cnt_q == limit - 1'b1);

    // R9: count is zero in the cycle after reset is asserted
    assert_wd_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
    // R2: an active count stays below the selected limit
    assert_wd_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < limit));
    // R3: disabled code never expires
    assert_wd_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_OFF) |-> !expire_o);
endmodule

// File: rtl/wdsup_top.sv
module wdsup_top
    import wdsup_pkg::*;
#(
    parameter int SETTLE_CYC = 5_000_000,
    parameter int WD_T0_CYC  = 10_000_000,
    parameter int WD_T1_CYC  = 30_000_000,
    parameter int WD_T2_CYC  = 70_000_000
) (
    input  logic       clk,
    input  logic       pwr_good_i,
    input  logic       supply_low_i,
    input  logic       wdi_cs_i,
    input  logic [1:0] wd_sel_i,
    input  logic       cause_clr_i,
    output logic       rst_drive_o,
    output logic       cause_wdog_o
);
    localparam int MAX_WD  = (WD_T0_CYC > WD_T1_CYC) ?
                             ((WD_T0_CYC > WD_T2_CYC) ? WD_T0_CYC : WD_T2_CYC) :
                             ((WD_T1_CYC > WD_T2_CYC) ? WD_T1_CYC : WD_T2_CYC);
    localparam int MAX_ALL = (MAX_WD > SETTLE_CYC) ? MAX_WD : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_ALL + 1) + 1;

    sup_state_e state_q, state_d;
    logic       low_s, wdi_s, wdi_prev_q, kick;
    logic       settle_run, settle_done, wd_run, wd_expire;
    logic       go_wdog, go_lowv, cause_q;

    wdsup_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_low_sync (
        .clk(clk), .rst_n(pwr_good_i), .d_i(supply_low_i), .q_o(low_s)
    );

    wdsup_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_wdi_sync (
        .clk(clk), .rst_n(pwr_good_i), .d_i(wdi_cs_i), .q_o(wdi_s)
    );

    always_ff @(posedge clk or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            wdi_prev_q <= 1'b1;
        end else begin
            wdi_prev_q <= wdi_s;
        end
    end

    assign kick = wdi_prev_q && !wdi_s;

    wdsup_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
        .clk(clk), .rst_n(pwr_good_i), .run_i(settle_run), .done_o(settle_done)
    );

    wdsup_wd_timer #(
        .WD_T0_CYC(WD_T0_CYC), .WD_T1_CYC(WD_T1_CYC),
        .WD_T2_CYC(WD_T2_CYC), .CNT_W(CNT_W)
    ) u_wd (
        .clk(clk), .rst_n(pwr_good_i), .run_i(wd_run), .kick_i(kick),
        .sel_i(wd_sel_i), .expire_o(wd_expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (low_s)            state_d = ST_LOWV;
                else if (settle_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (low_s)            state_d = ST_LOWV;
                else if (wd_expire)   state_d = ST_WDOG;
            end
            ST_LOWV: begin
                if (!low_s)           state_d = ST_HOLD;
            end
            ST_WDOG: begin
                if (low_s)            state_d = ST_LOWV;
                else if (settle_done) state_d = ST_RUN;
            end
            default:                  state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        rst_drive_o = (state_q != ST_RUN);
        settle_run  = (state_q == ST_HOLD) || (state_q == ST_WDOG);
        wd_run      = (state_q == ST_RUN);
        go_wdog     = (state_q != ST_WDOG) && (state_d == ST_WDOG);
        go_lowv     = (state_q != ST_LOWV) && (state_d == ST_LOWV);
    end

    // volatile cause flag
    always_ff @(posedge clk or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            cause_q <= 1'b0;
        end else if (go_wdog) begin
            cause_q <= 1'b1;
        end else if (go_lowv || cause_clr_i) begin
            cause_q <= 1'b0;
        end
    end

    assign cause_wdog_o = cause_q;

    // R5: synchronised low flag forces reset on the following edge
    assert_lowv_reset_R5: assert property (@(posedge clk) disable iff (!pwr_good_i)
        $rose(low_s) |=> rst_drive_o);
    // R7: a timeout taken in run sets the cause flag
    assert_cause_set_R7: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (wd_run && wd_expire && !low_s) |=> (cause_wdog_o && rst_drive_o));
    // R8: clear strobe without a competing event clears the flag
    assert_cause_clr_R8: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (cause_clr_i && !go_wdog) |=> !cause_wdog_o);
    // R4: a service edge in run never leads straight into reset
    assert_kick_holds_R4: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (wd_run && kick && !low_s) |=> !rst_drive_o);
endmodule

// File: tb/wdsup_top_bench.sv
module wdsup_top_bench;
    localparam int SETTLE = 20;
    localparam int T0 = 30, T1 = 50, T2 = 80;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       supply_low = 1'b0;
    logic       wdi = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       clr = 1'b0;
    logic       rst_drive, cause;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wdsup_top #(.SETTLE_CYC(SETTLE), .WD_T0_CYC(T0), .WD_T1_CYC(T1), .WD_T2_CYC(T2)) u_wdsup_top (
        .clk(clk), .pwr_good_i(pwr_good), .supply_low_i(supply_low), .wdi_cs_i(wdi),
        .wd_sel_i(sel), .cause_clr_i(clr), .rst_drive_o(rst_drive), .cause_wdog_o(cause)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count rising edges while rst_drive keeps the level lvl
    task automatic measure(input logic lvl, output int n);
        n = 0;
        while (rst_drive == lvl && n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
        end
    endtask

    task automatic power_cycle(input logic [1:0] s);
        int n;
        @(negedge clk);
        pwr_good = 1'b0; sel = s; supply_low = 1'b0; wdi = 1'b1; clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 drive in power-down", int'(rst_drive), 1);
        check("R7 cause after power-up", int'(cause), 0);
        pwr_good = 1'b1;
        measure(1'b1, n);
        check("R1 power-up settle length", n, SETTLE);
    endtask

    task automatic kick();
        wdi = 1'b0;
        repeat (2) @(negedge clk);
        wdi = 1'b1;
    endtask

    initial begin
        int n, lim;
        bit bad;
        @(negedge clk);
        // R2 R6 R7 R8 R9: sweep the three interval codes
        for (int s = 0; s < 3; s++) begin
            lim = (s == 0) ? T0 : (s == 1) ? T1 : T2;
            power_cycle(2'(s));
            measure(1'b0, n);
            check("R2 interval length", n, lim);
            check("R7 cause after timeout", int'(cause), 1);
            measure(1'b1, n);
            check("R6 watchdog reset length", n, SETTLE);
            measure(1'b0, n);
            check("R9 full interval after reset", n, lim);
            clr = 1'b1; @(negedge clk); clr = 1'b0;
            check("R8 cause cleared", int'(cause), 0);
        end
        // R3: disabled code
        power_cycle(2'd3);
        bad = 0;
        repeat (300) begin @(negedge clk); if (rst_drive) bad = 1; end
        check("R3 no timeout when disabled", int'(bad), 0);
        // R4: periodic service keeps reset released
        power_cycle(2'd0);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            kick();
            repeat (13) begin @(negedge clk); if (rst_drive) bad = 1; end
        end
        check("R4 service edges keep reset off", int'(bad), 0);
        // R4: held low gives no service
        wdi = 1'b0;
        bad = 0;
        repeat (40) begin @(negedge clk); if (rst_drive) bad = 1; end
        check("R4 steady low does not service", int'(bad), 1);
        wdi = 1'b1;
        // R5 R7: low supply during watchdog reset
        power_cycle(2'd0);
        measure(1'b0, n);
        check("R7 cause set before low supply", int'(cause), 1);
        supply_low = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 cause cleared by low supply", int'(cause), 0);
        bad = 0;
        repeat (100) begin @(negedge clk); if (!rst_drive) bad = 1; end
        check("R5 reset held while supply low", int'(bad), 0);
        supply_low = 1'b0;
        measure(1'b1, n);
        check("R5 release after supply return", n, SETTLE + 3);
        // R5: low supply during run, assertion latency
        repeat (5) @(negedge clk);
        supply_low = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 not yet asserted after two edges", int'(rst_drive), 0);
        @(negedge clk);
        check("R5 asserted on third edge", int'(rst_drive), 1);
        supply_low = 1'b0;
        measure(1'b1, n);
        check("R5 release after short low", n, SETTLE + 3);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule